// File: doc/BRIEF.md
# Prioritized Edge Interrupt Controller

This block collects interrupt requests for a small microcontroller core. It watches a set of external interrupt pins (five by default) and one watchdog event line. Each external pin has a byte-wide control register. In that register software chooses the trigger edge, turns the source on or off, and gives it a two-bit priority level. The register also exposes a pending-request flag. A selected edge on a pin sets that flag whether or not the source is enabled. The watchdog event sets a separate flag that cannot be masked.

Every cycle the block looks at all pending, enabled sources whose level is below the mask level presented by the CPU. It reports one winner: the lowest level wins, and among sources on the same level the lowest index wins. A level of 3 removes a source from arbitration entirely. A pending watchdog flag overrides every external source. Software reads and writes the registers through a simple bus made of an address, a write strobe and write and read data, with the read data returned combinationally. Software clears a request flag by writing 0 to it. A hardware event that lands in the same cycle as that write keeps the flag set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `int_req`, `int_nmi`, `int_vec` and `int_lvl` are 0.
- R2: Address 0 is the watchdog register, with its flag at bit 1 and all other bits reading 0. Address 1+i is the control register of source i: bits 7:6 hold the level, bit 5 selects the edge (1 = rising, 0 = falling), bit 1 is the enable and bit 0 is the request flag. Bits 4:2 read 0 and ignore writes.
- R3: Only the selected edge on a pin sets that source's request flag. The flag is visible after the third rising clock edge following the pin change, because the pin passes through two synchronizer flops and then the edge detector.
- R4: A selected edge sets the request flag even while the enable bit is 0, but a disabled source never drives `int_req`.
- R5: A source is eligible only when its request and enable bits are both 1 and its level is below `cpu_mask`. With no eligible source and no watchdog flag, `int_req`, `int_vec` and `int_lvl` are 0.
- R6: A source whose level field is 3 is never reported, whatever its enable and request bits hold.
- R7: Among eligible sources the lowest level wins. On a tie in level, the lowest index wins.
- R8: While an external source wins, `int_req` is 1, `int_nmi` is 0, `int_vec` is the index of the source and `int_lvl` is its level.
- R9: A pulse on `wdt_event` sets the watchdog flag at the next clock edge. While that flag is set, the outputs are `int_req`=1, `int_nmi`=1, `int_vec`=N_SRC (5 by default) and `int_lvl`=0, whatever the external sources hold.
- R10: Writing the request bit replaces the flag: a 0 clears it and a 1 sets it. If an edge is detected in the same cycle as a write of 0, the flag stays 1.
- R11: Writing 0 to bit 1 of address 0 clears the watchdog flag, unless `wdt_event` is high in that same cycle, in which case the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | N_SRC | Asynchronous external interrupt pins |
| wdt_event | input | 1 | Watchdog interrupt event, one-cycle pulse |
| cpu_mask | input | 2 | CPU mask level; only levels below it are reported |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| int_req | output | 1 | An interrupt is being requested |
| int_nmi | output | 1 | The request is the non-maskable watchdog |
| int_vec | output | VEC_W | Index of the winning source; N_SRC for the watchdog |
| int_lvl | output | 2 | Level of the winning source |

## Verification
Arbitration is tried against several patterns:
- Pending sources on different levels show that level outranks index.
- Two sources on the same level show that the lower index breaks the tie.
- Sweeping `cpu_mask` over one fixed set of requests separates the strict "below the mask" comparison from a "less or equal" one.
- A level-3 source is enabled and pending and sits beside a lower-level source, then is left alone. This shows that level 3 is excluded rather than merely outranked.

Edge handling is tried with rising and falling selects and with the opposite edge on each pin. The cycle in which the flag appears is sampled against both one cycle early and on time. Separate patterns place an edge, or a watchdog pulse, in the very cycle of a clearing write, so that the hardware-wins rule is told apart from a last-write-wins rule.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int DATA_W   = 8;
   localparam int LVL_W    = 2;
   localparam int BIT_REQ  = 0;
   localparam int BIT_EN   = 1;
   localparam int BIT_EDGE = 5;
   localparam int BIT_LVL  = 6;
   localparam int BIT_WDF  = 1;
   localparam logic [LVL_W-1:0] LVL_OFF = '1;

   typedef struct packed {
      logic [LVL_W-1:0] lvl;
      logic             rise;
      logic             en;
      logic             req;
   } src_cfg_t;

   function automatic logic [DATA_W-1:0] cfg_to_byte(input src_cfg_t c);
      logic [DATA_W-1:0] b;
      b = '0;
      b[BIT_LVL +: LVL_W] = c.lvl;
      b[BIT_EDGE]         = c.rise;
      b[BIT_EN]           = c.en;
      b[BIT_REQ]          = c.req;
      return b;
   endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);
   logic [STAGES-1:0] chain;
   logic              prev;
   logic              synced;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= pin;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin};
         end
      end
   endgenerate

   assign synced = chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= synced;
   end

   assign edge_hit = rise_sel ? (synced & ~prev) : (~synced & prev);
endmodule

// File: rtl/irq_src_reg.sv
module irq_src_reg
   import irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_hit,
   input  src_cfg_t wr_cfg,
   input  logic     edge_hit,
   output src_cfg_t cfg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else begin
         if (wr_hit) begin
            cfg.lvl  <= wr_cfg.lvl;
            cfg.rise <= wr_cfg.rise;
            cfg.en   <= wr_cfg.en;
         end
         cfg.req <= edge_hit | (wr_hit ? wr_cfg.req : cfg.req);
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int N_SRC = 5,
   parameter int VEC_W = 3
) (
   input  src_cfg_t [N_SRC-1:0] cfg,
   input  logic                 nmi_flag,
   input  logic [LVL_W-1:0]     cpu_mask,
   output logic                 int_req,
   output logic                 int_nmi,
   output logic [VEC_W-1:0]     int_vec,
   output logic [LVL_W-1:0]     int_lvl
);
   logic [N_SRC-1:0] elig;
   logic             found;
   logic [LVL_W-1:0] best_lvl;
   logic [VEC_W-1:0] best_idx;

   genvar g;
   generate
      for (g = 0; g < N_SRC; g++) begin : g_elig
         assign elig[g] = cfg[g].req & cfg[g].en &
                          (cfg[g].lvl != LVL_OFF) & (cfg[g].lvl < cpu_mask);
      end
   endgenerate

   always_comb begin
      found    = 1'b0;
      best_lvl = '0;
      best_idx = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!found || cfg[i].lvl < best_lvl)) begin
            found    = 1'b1;
            best_lvl = cfg[i].lvl;
            best_idx = VEC_W'(i);
         end
      end
   end

   always_comb begin
      if (nmi_flag) begin
         int_req = 1'b1;
         int_nmi = 1'b1;
         int_vec = VEC_W'(N_SRC);
         int_lvl = '0;
      end else begin
         int_req = found;
         int_nmi = 1'b0;
         int_vec = best_idx;
         int_lvl = best_lvl;
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int N_SRC       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3,
   localparam int VEC_W      = $clog2(N_SRC + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_SRC-1:0]      irq_pin,
   input  logic                  wdt_event,
   input  logic [LVL_W-1:0]      cpu_mask,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  int_req,
   output logic                  int_nmi,
   output logic [VEC_W-1:0]      int_vec,
   output logic [LVL_W-1:0]      int_lvl
);
   if (N_SRC < 1 || N_SRC + 1 > (1 << ADDR_W)) begin : g_bad_map
      $error("irq_prio_ctrl: N_SRC does not fit the address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_prio_ctrl: at least two synchronizer stages required");
   end

   src_cfg_t [N_SRC-1:0] cfg_q;
   logic     [N_SRC-1:0] req_bits;
   logic     [N_SRC-1:0] en_bits;
   logic                 nmi_q;
   src_cfg_t             wr_cfg;
   logic                 unused_wbits;

   assign wr_cfg = '{lvl:  bus_wdata[BIT_LVL +: LVL_W],
                     rise: bus_wdata[BIT_EDGE],
                     en:   bus_wdata[BIT_EN],
                     req:  bus_wdata[BIT_REQ]};
   assign unused_wbits = ^bus_wdata[4:2];

   genvar g;
   generate
      for (g = 0; g < N_SRC; g++) begin : g_src
         logic edge_hit;
         logic wr_hit;
         assign wr_hit = bus_we && (bus_addr == ADDR_W'(g + 1));

         irq_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (irq_pin[g]),
            .rise_sel (cfg_q[g].rise),
            .edge_hit (edge_hit)
         );

         irq_src_reg u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit),
            .wr_cfg   (wr_cfg),
            .edge_hit (edge_hit),
            .cfg      (cfg_q[g])
         );

         assign req_bits[g] = cfg_q[g].req;
         assign en_bits[g]  = cfg_q[g].en;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q <= 1'b0;
      end else begin
         nmi_q <= wdt_event |
                  ((bus_we && bus_addr == '0) ? bus_wdata[BIT_WDF] : nmi_q);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata[BIT_WDF] = nmi_q;
      for (int i = 0; i < N_SRC; i++) begin
         if (bus_addr == ADDR_W'(i + 1)) bus_rdata = cfg_to_byte(cfg_q[i]);
      end
   end

   irq_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
      .cfg      (cfg_q),
      .nmi_flag (nmi_q),
      .cpu_mask (cpu_mask),
      .int_req  (int_req),
      .int_nmi  (int_nmi),
      .int_vec  (int_vec),
      .int_lvl  (int_lvl)
   );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int N_SRC  = 5,
   parameter int ADDR_W = 3,
   parameter int VEC_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cpu_mask,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [7:0]        bus_rdata,
   input logic              int_req,
   input logic              int_nmi,
   input logic [VEC_W-1:0]  int_vec,
   input logic [1:0]        int_lvl,
   input logic              nmi_q,
   input logic [N_SRC-1:0]  req_bits,
   input logic [N_SRC-1:0]  en_bits
);
   AST_NMI_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |-> (int_req && int_nmi && int_vec == VEC_W'(N_SRC) && int_lvl == 2'd0)); // R9

   AST_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_nmi) |-> (int_lvl < cpu_mask && int_lvl != 2'd3)); // R5

   AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_nmi) |-> (int_vec < VEC_W'(N_SRC) &&
                                 req_bits[int_vec] && en_bits[int_vec])); // R8

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !int_req |-> (int_vec == '0 && int_lvl == 2'd0 && !int_nmi)); // R5

   AST_RESV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[4:2] == 3'b000); // R2

   genvar g;
   generate
      for (g = 0; g < N_SRC; g++) begin : g_sticky
         AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (req_bits[g] && !(bus_we && bus_addr == ADDR_W'(g + 1))) |=> req_bits[g]); // R10
      end
   endgenerate
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_mask  (cpu_mask),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .int_req   (int_req),
   .int_nmi   (int_nmi),
   .int_vec   (int_vec),
   .int_lvl   (int_lvl),
   .nmi_q     (nmi_q),
   .req_bits  (req_bits),
   .en_bits   (en_bits)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] irq_pin = '0;
   logic       wdt_event = 1'b0;
   logic [1:0] cpu_mask = 2'd3;
   logic [2:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       int_req;
   logic       int_nmi;
   logic [2:0] int_vec;
   logic [1:0] int_lvl;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wdt_event(wdt_event),
      .cpu_mask(cpu_mask), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_req(int_req),
      .int_nmi(int_nmi), .int_vec(int_vec), .int_lvl(int_lvl)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 3'(a);
      #1 v = int'(bus_rdata);
   endtask

   // packs {req, nmi, vec, lvl} into one word for comparison
   function automatic int outs();
      return {int_req, int_nmi, int_vec, int_lvl};
   endfunction

   function automatic int exp_outs(input int r, input int n, input int vec, input int l);
      return (r << 6) | (n << 5) | (vec << 2) | l;
   endfunction

   task automatic pin_set(input int i, input logic v);
      @(negedge clk);
      irq_pin[i] = v;
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         chk($sformatf("R1 reset reg %0d", a), v, 0);
      end
      chk("R1 reset outputs", outs(), 0);
   endtask

   task automatic t_layout();
      int v;
      wr(3, 8'hFF);
      rd(3, v);
      chk("R2 layout reserved bits read 0", v, 8'hE3);
      chk("R6 level3 pending enabled not reported", outs(), 0);
      wr(3, 8'h00);
      rd(0, v);
      chk("R2 watchdog reg idle", v, 0);
   endtask

   task automatic t_edges();
      int v;
      wr(1, 8'h22);  // src0 rising, enabled, level 0
      pin_set(0, 1'b1);
      @(negedge clk);
      @(negedge clk);
      chk("R3 no request one cycle early", int'(int_req), 0);
      @(negedge clk);
      chk("R3 R8 rising edge request on 3rd edge", outs(), exp_outs(1, 0, 0, 0));
      wr(1, 8'h22);  // clear
      pin_set(0, 1'b0);
      repeat (4) @(negedge clk);
      rd(1, v);
      chk("R3 falling edge ignored on rising select", v, 8'h22);
      wr(1, 8'h00);
      wr(2, 8'h02);  // src1 falling, enabled
      pin_set(1, 1'b1);
      repeat (4) @(negedge clk);
      rd(2, v);
      chk("R3 rising edge ignored on falling select", v, 8'h02);
      pin_set(1, 1'b0);
      repeat (3) @(negedge clk);
      rd(2, v);
      chk("R3 falling edge sets request", v, 8'h03);
      wr(2, 8'h00);
   endtask

   task automatic t_disabled();
      int v;
      wr(4, 8'h20);  // src3 rising, disabled
      pin_set(3, 1'b1);
      repeat (3) @(negedge clk);
      rd(4, v);
      chk("R4 edge sets request while disabled", v, 8'h21);
      chk("R4 disabled source not reported", int'(int_req), 0);
      wr(4, 8'h00);
      pin_set(3, 1'b0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_priority();
      wr(2, 8'h83);  // src1 level 2
      wr(4, 8'h43);  // src3 level 1
      wr(5, 8'h43);  // src4 level 1
      @(negedge clk);
      chk("R7 lower level and lower index win", outs(), exp_outs(1, 0, 3, 1));
      cpu_mask = 2'd1;
      #1 chk("R5 level equal to mask blocked", outs(), 0);
      cpu_mask = 2'd2;
      #1 chk("R5 level below mask passes", outs(), exp_outs(1, 0, 3, 1));
      cpu_mask = 2'd3;
      wr(5, 8'h03);  // src4 level 0
      chk("R7 level beats index", outs(), exp_outs(1, 0, 4, 0));
      wr(3, 8'hC3);  // src2 level 3
      chk("R6 level3 does not disturb winner", outs(), exp_outs(1, 0, 4, 0));
      wr(5, 8'h00);
      wr(4, 8'h00);
      wr(2, 8'h00);
      chk("R6 lone level3 source not reported", outs(), 0);
      wr(3, 8'h00);
      wr(3, 8'h01);  // software set without enable
      chk("R10 write 1 sets request", int'(bus_rdata), 8'h01);
      wr(3, 8'h00);
   endtask

   task automatic t_race();
      int v;
      wr(3, 8'h20);  // src2 rising, disabled
      pin_set(2, 1'b1);
      @(negedge clk);
      @(negedge clk);
      bus_addr = 3'd3; bus_wdata = 8'h20; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd(3, v);
      chk("R10 edge beats clearing write", v, 8'h21);
      wr(3, 8'h20);
      rd(3, v);
      chk("R10 write 0 clears request", v, 8'h20);
      pin_set(2, 1'b0);
      repeat (4) @(negedge clk);
      wr(3, 8'h00);
   endtask

   task automatic t_nmi();
      int v;
      wr(2, 8'h43);  // src1 level 1 pending
      @(negedge clk);
      wdt_event = 1'b1;
      @(negedge clk);
      wdt_event = 1'b0;
      chk("R9 watchdog overrides external", outs(), exp_outs(1, 1, 5, 0));
      rd(0, v);
      chk("R9 watchdog flag bit 1", v, 8'h02);
      @(negedge clk);
      bus_addr = 3'd0; bus_wdata = 8'h00; bus_we = 1'b1; wdt_event = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; wdt_event = 1'b0;
      rd(0, v);
      chk("R11 event beats clearing write", v, 8'h02);
      wr(0, 8'h00);
      rd(0, v);
      chk("R11 write 0 clears watchdog", v, 0);
      chk("R8 external resumes after clear", outs(), exp_outs(1, 0, 1, 1));
      wr(2, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_edges();
      t_disabled();
      t_priority();
      t_race();
      t_nmi();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule